// File: doc/BRIEF.md
# TSB Pointer Generator

When a translation lookup misses, software needs the address of the translation-storage-buffer slot that might hold the missing entry. This block computes that address. It takes a faulting tag-access value and two TSB descriptor sets, one for context zero and one shared by every other context. It returns two 64-bit pointers together, one for each page-size slot.

A request enters on a valid/ready handshake and carries the tag-access value and both descriptor sets. One cycle after the request is accepted, the two pointers appear on the response side, also under valid/ready. The response register is a single stage. While a response is held and not taken, the block lowers its request-side ready, so back-pressure reaches the requester with no added delay. A new request is accepted in the same cycle that the held response is taken, which gives full throughput when the consumer is always ready.

Each descriptor set is split into fields:
- a base address (pointer bits 63:13),
- a split flag,
- a 4-bit size code,
- a 3-bit page-size code for each slot.

Top module: `tsbptr_gen`

## Requirements
- R1: When tag_access bits 12:0 are all zero, the `z_*` descriptor set is used; any non-zero value there selects the `n_*` set.
- R2: Pointer bits 12:0 hold no base contribution, and bits 3:0 of both pointers are always zero.
- R3: Pointer bits (12 + size code) down to 4 are the OR of the base with (tag_access shifted right by 9 + 3 × page-size code). All other bits outside the split position equal the base. With the size code at 15 the field reaches bit 27.
- R4: Slot 0 takes its page-size code from the `pgsz0` field of the selected set, and slot 1 takes its code from `pgsz1`.
- R5: Slot 1 has bit (13 + size code) set when the selected split flag is 1. Slot 0 never receives this bit.
- R6: A request is accepted on a rising edge where req_valid and req_ready are both 1. Its pointers are presented with rsp_valid = 1 from the next cycle on.
- R7: While rsp_valid = 1 and rsp_ready = 0, req_ready is 0 and both pointers and rsp_valid hold their values.
- R8: While rst_n is low, and in the cycle after it, rsp_valid is 0. After reset, req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| tag_access | input | 64 | Faulting VA bits 63:13 with the context in bits 12:0 |
| z_base | input | 51 | Context-zero TSB base (address bits 63:13) |
| z_split | input | 1 | Context-zero split flag |
| z_size | input | 4 | Context-zero size code |
| z_pgsz0 | input | 3 | Context-zero page-size code, slot 0 |
| z_pgsz1 | input | 3 | Context-zero page-size code, slot 1 |
| n_base | input | 51 | Non-zero-context TSB base (address bits 63:13) |
| n_split | input | 1 | Non-zero-context split flag |
| n_size | input | 4 | Non-zero-context size code |
| n_pgsz0 | input | 3 | Non-zero-context page-size code, slot 0 |
| n_pgsz1 | input | 3 | Non-zero-context page-size code, slot 1 |
| rsp_valid | output | 1 | Pointers present |
| rsp_ready | input | 1 | Consumer takes the pointers this cycle |
| ptr_slot0 | output | 64 | Pointer for page-size slot 0 |
| ptr_slot1 | output | 64 | Pointer for page-size slot 1 |

## Verification
A wrong context decision swaps whole descriptor sets, so the base bits of both pointers differ from the expected value in the first response of a request that has a non-zero context. A fault in the index or split path shows only in particular bit fields. It appears one cycle after acceptance, in the response whose size or page-size code reaches the faulty bits, which is why the codes are swept across their range. A corrupted handshake state shows within a cycle as a lost, duplicated or changed response while back-pressure is applied.

// File: rtl/tsbptr_pkg.sv
package tsbptr_pkg;
  localparam int unsigned ADDR_W     = 64;
  localparam int unsigned CTX_W      = 13;
  localparam int unsigned BASE_LSB   = 13;
  localparam int unsigned BASE_W     = ADDR_W - BASE_LSB;
  localparam int unsigned SIZE_W     = 4;
  localparam int unsigned PGSZ_W     = 3;
  localparam int unsigned IDX_LSB    = 4;
  localparam int unsigned IDX_HI0    = 12;
  localparam int unsigned SHIFT_BASE = 9;
  localparam int unsigned SHIFT_STEP = 3;
  localparam int unsigned SHAMT_W    = 6;
  localparam int unsigned NUM_SLOTS  = 2;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic              split;
    logic [SIZE_W-1:0] size;
    logic [PGSZ_W-1:0] pgsz1;
    logic [PGSZ_W-1:0] pgsz0;
  } tsb_desc_t;
endpackage

// File: rtl/tsbptr_ctx_sel.sv
module tsbptr_ctx_sel
  import tsbptr_pkg::*;
(
  input  logic [ADDR_W-1:0] tag_access,
  input  tsb_desc_t         zero_desc,
  input  tsb_desc_t         other_desc,
  output tsb_desc_t         sel_desc
);
  logic ctx_is_zero;

  always_comb begin
    ctx_is_zero = (tag_access[CTX_W-1:0] == '0);
    sel_desc    = ctx_is_zero ? zero_desc : other_desc;
  end
endmodule

// File: rtl/tsbptr_slot_calc.sv
module tsbptr_slot_calc
  import tsbptr_pkg::*;
(
  input  logic [ADDR_W-1:0] tag_access,
  input  logic [BASE_W-1:0] base,
  input  logic              split_en,
  input  logic [SIZE_W-1:0] size_code,
  input  logic [PGSZ_W-1:0] pgsz_code,
  output logic [ADDR_W-1:0] ptr
);
  logic [SHAMT_W-1:0] shamt;
  logic [ADDR_W-1:0]  shifted;
  logic [ADDR_W-1:0]  idx_mask;
  logic [ADDR_W-1:0]  split_vec;
  int                 idx_hi;
  int                 split_pos;

  always_comb begin
    shamt   = SHAMT_W'(SHIFT_BASE) + SHAMT_W'(pgsz_code) * SHAMT_W'(SHIFT_STEP);
    shifted = tag_access >> shamt;

    idx_hi = int'(IDX_HI0) + int'(size_code);
    if (idx_hi > int'(ADDR_W) - 1) idx_hi = int'(ADDR_W) - 1;
    for (int i = 0; i < int'(ADDR_W); i++)
      idx_mask[i] = (i >= int'(IDX_LSB)) && (i <= idx_hi);

    split_pos = int'(BASE_LSB) + int'(size_code);
    if (split_pos > int'(ADDR_W) - 1) split_pos = int'(ADDR_W) - 1;
    split_vec = '0;
    if (split_en) split_vec[split_pos] = 1'b1;

    ptr = {base, {BASE_LSB{1'b0}}} | split_vec | (shifted & idx_mask);
  end
endmodule

// File: rtl/tsbptr_out_stage.sv
module tsbptr_out_stage #(
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              held_q;
  logic [DATA_W-1:0] data_q;

  assign in_ready  = !held_q || out_ready;
  assign out_valid = held_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (in_ready) begin
      held_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) data_q <= in_data;
  end
endmodule

// File: rtl/tsbptr_gen.sv
module tsbptr_gen
  import tsbptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       tag_access,
  input  logic [50:0]       z_base,
  input  logic              z_split,
  input  logic [3:0]        z_size,
  input  logic [2:0]        z_pgsz0,
  input  logic [2:0]        z_pgsz1,
  input  logic [50:0]       n_base,
  input  logic              n_split,
  input  logic [3:0]        n_size,
  input  logic [2:0]        n_pgsz0,
  input  logic [2:0]        n_pgsz1,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       ptr_slot0,
  output logic [63:0]       ptr_slot1
);
  localparam int unsigned STAGE_W = NUM_SLOTS * ADDR_W;

  tsb_desc_t zero_desc, other_desc, sel_desc;
  logic [STAGE_W-1:0] slot_ptrs;
  logic [STAGE_W-1:0] held_ptrs;

  assign zero_desc  = '{base: z_base, split: z_split, size: z_size,
                        pgsz1: z_pgsz1, pgsz0: z_pgsz0};
  assign other_desc = '{base: n_base, split: n_split, size: n_size,
                        pgsz1: n_pgsz1, pgsz0: n_pgsz0};

  tsbptr_ctx_sel u_sel (
    .tag_access (tag_access),
    .zero_desc  (zero_desc),
    .other_desc (other_desc),
    .sel_desc   (sel_desc)
  );

  for (genvar s = 0; s < int'(NUM_SLOTS); s++) begin : g_slot
    logic [PGSZ_W-1:0] pgsz;
    logic              split_en;
    if (s == 0) begin : g_first
      assign pgsz     = sel_desc.pgsz0;
      assign split_en = 1'b0;
    end else begin : g_second
      assign pgsz     = sel_desc.pgsz1;
      assign split_en = sel_desc.split;
    end

    tsbptr_slot_calc u_calc (
      .tag_access (tag_access),
      .base       (sel_desc.base),
      .split_en   (split_en),
      .size_code  (sel_desc.size),
      .pgsz_code  (pgsz),
      .ptr        (slot_ptrs[s*ADDR_W +: ADDR_W])
    );
  end

  tsbptr_out_stage #(.DATA_W(STAGE_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (slot_ptrs),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (held_ptrs)
  );

  assign ptr_slot0 = held_ptrs[0 +: ADDR_W];
  assign ptr_slot1 = held_ptrs[ADDR_W +: ADDR_W];
endmodule

// File: rtl/tsbptr_gen_chk.sv
module tsbptr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [63:0] ptr_slot0,
  input logic [63:0] ptr_slot1
);
  assert_accept_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(ptr_slot0) && $stable(ptr_slot1)));

  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_low_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (ptr_slot0[3:0] == 4'd0 && ptr_slot1[3:0] == 4'd0));

  assert_reset_idle_R8: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);
endmodule

bind tsbptr_gen tsbptr_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .ptr_slot0 (ptr_slot0),
  .ptr_slot1 (ptr_slot1)
);

// File: tb/tsbptr_gen_tb_top.sv
module tsbptr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] tag_access = '0;
  logic [50:0] z_base = '0, n_base = '0;
  logic        z_split = 1'b0, n_split = 1'b0;
  logic [3:0]  z_size = '0, n_size = '0;
  logic [2:0]  z_pgsz0 = '0, z_pgsz1 = '0, n_pgsz0 = '0, n_pgsz1 = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] ptr_slot0, ptr_slot1;

  int n_checks = 0;
  int n_fails  = 0;
  bit hold_low = 1'b0;
  bit rand_mode = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] p0;
    logic [63:0] p1;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  tsbptr_gen dut_i (.*);

  always @(posedge clk) begin
    #1;
    if (hold_low) rsp_ready = 1'b0;
    else if (rand_mode) rsp_ready = ($urandom % 3) != 0;
    else rsp_ready = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_ptr(input logic [63:0] tag, input logic [50:0] base,
                                          input logic split, input logic [3:0] sz,
                                          input logic [2:0] ps, input bit second);
    logic [63:0] p, idx;
    p = {base, 13'b0};
    if (second && split) p[13 + sz] = 1'b1;
    idx = tag >> (9 + 3 * ps);
    for (int i = 4; i <= 12 + int'(sz); i++) p[i] = p[i] | idx[i];
    return p;
  endfunction

  task automatic send(input logic [63:0] tag,
                      input logic [50:0] zb, input logic zs, input logic [3:0] zz, input logic [2:0] z0, input logic [2:0] z1,
                      input logic [50:0] nb, input logic ns, input logic [3:0] nz, input logic [2:0] n0, input logic [2:0] n1,
                      input string tag_s);
    exp_t e;
    bit zero;
    @(negedge clk);
    tag_access = tag;
    z_base = zb; z_split = zs; z_size = zz; z_pgsz0 = z0; z_pgsz1 = z1;
    n_base = nb; n_split = ns; n_size = nz; n_pgsz0 = n0; n_pgsz1 = n1;
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    zero = (tag[12:0] == 13'd0);
    e.p0 = zero ? ref_ptr(tag, zb, zs, zz, z0, 1'b0) : ref_ptr(tag, nb, ns, nz, n0, 1'b0);
    e.p1 = zero ? ref_ptr(tag, zb, zs, zz, z1, 1'b1) : ref_ptr(tag, nb, ns, nz, n1, 1'b1);
    e.tag = tag_s;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compares every response taken by the consumer.
  always @(negedge clk) begin
    #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R6 unexpected response", ptr_slot0, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(ptr_slot0 === e.p0, {e.tag, " slot0"}, ptr_slot0, e.p0);
        check(ptr_slot1 === e.p1, {e.tag, " slot1"}, ptr_slot1, e.p1);
      end
    end
  end

  task automatic drain();
    int guard = 0;
    while (sb_q.size() != 0 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    check(sb_q.size() == 0, "R6 drain", 64'(sb_q.size()), 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] snap0, snap1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    // R8: reset state
    check(rsp_valid === 1'b0, "R8 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check(req_ready === 1'b1, "R8 req_ready after reset", 64'(req_ready), 64'd1);

    // R1: context zero picks the z set, non-zero picks the n set
    send(64'hFEDC_BA98_7654_2000, 51'h1_2345_6789_ABCD, 1'b0, 4'd2, 3'd0, 3'd1,
         51'h7_7777_0000_1111, 1'b1, 4'd3, 3'd2, 3'd3, "R1 R3 R4 zero ctx");
    send(64'hFEDC_BA98_7654_2001, 51'h1_2345_6789_ABCD, 1'b0, 4'd2, 3'd0, 3'd1,
         51'h7_7777_0000_1111, 1'b1, 4'd3, 3'd2, 3'd3, "R1 R5 nonzero ctx");
    // R5: split on both sets, slot0 must not get the bit
    send(64'h0000_0000_0000_0000, 51'h0, 1'b1, 4'd5, 3'd0, 3'd0,
         51'h0, 1'b0, 4'd0, 3'd0, 3'd0, "R5 split bit 18");
    send(64'h0000_0000_0000_1FFF, 51'h0, 1'b0, 4'd0, 3'd0, 3'd0,
         51'h0, 1'b1, 4'd15, 3'd0, 3'd0, "R5 split bit 28");
    // R3: size code extremes with an all-ones tag
    send(64'hFFFF_FFFF_FFFF_E000, 51'h0, 1'b0, 4'd0, 3'd0, 3'd7,
         51'h0, 1'b0, 4'd0, 3'd0, 3'd0, "R3 size 0");
    send(64'hFFFF_FFFF_FFFF_E000, 51'h0, 1'b0, 4'd15, 3'd0, 3'd7,
         51'h0, 1'b0, 4'd0, 3'd0, 3'd0, "R3 size 15");
    // R4: each slot uses its own page-size code
    send(64'h0123_4567_89AB_C0DE, 51'h0, 1'b0, 4'd0, 3'd0, 3'd0,
         51'h0, 1'b0, 4'd9, 3'd1, 3'd5, "R4 distinct codes");
    send(64'h0123_4567_89AB_C0DE, 51'h0, 1'b0, 4'd0, 3'd0, 3'd0,
         51'h0, 1'b0, 4'd9, 3'd7, 3'd0, "R4 swapped codes");
    idle();
    drain();

    // R6/R7: one response held under back-pressure
    hold_low = 1'b1;
    @(posedge clk);
    send(64'h0000_0ABC_DEF0_0042, 51'h3, 1'b0, 4'd1, 3'd1, 3'd2,
         51'h5_5555_5555_5555, 1'b1, 4'd7, 3'd4, 3'd6, "R6 R7 held item");
    idle();
    #3;
    check(rsp_valid === 1'b1, "R6 valid one cycle after accept", 64'(rsp_valid), 64'd1);
    check(req_ready === 1'b0, "R7 ready low while held", 64'(req_ready), 64'd0);
    snap0 = ptr_slot0;
    snap1 = ptr_slot1;
    repeat (3) @(negedge clk);
    #3;
    check(rsp_valid === 1'b1, "R7 valid kept", 64'(rsp_valid), 64'd1);
    check(ptr_slot0 === snap0, "R7 slot0 stable", ptr_slot0, snap0);
    check(ptr_slot1 === snap1, "R7 slot1 stable", ptr_slot1, snap1);
    hold_low = 1'b0;
    drain();

    // Random traffic under random back-pressure
    rand_mode = 1'b1;
    for (int k = 0; k < 300; k++) begin
      logic [63:0] t;
      t = {$urandom, $urandom};
      if (k % 4 == 0) t[12:0] = 13'd0;
      send(t, {$urandom, $urandom}, 1'($urandom), 4'($urandom), 3'($urandom), 3'($urandom),
           {$urandom, $urandom}, 1'($urandom), 4'($urandom), 3'($urandom), 3'($urandom),
           "R1 R3 R4 R5 random");
    end
    idle();
    rand_mode = 1'b0;
    drain();
    finish_run();
  end
endmodule